// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital control and status logic in front of a successive-approximation converter. Software reaches it through one 8-bit control/status byte. That byte turns the converter on, starts conversions, selects auto-triggering, holds the completion flag and its interrupt enable, and picks the clock prescaler. A prescaler derives the converter clock from the system clock. A sequencer inserts a one-time warm-up interval on the first conversion after enable, then counts a fixed-length conversion. The analog converter itself is modelled by a counter of converter clocks.

A conversion can begin in three ways: a software start, a rising edge on an external trigger, or continuous back-to-back operation. When a conversion completes, the block pulses a result-load strobe and sets the completion flag in the same cycle. An interrupt request is raised when the flag, the local enable and a global enable are all set.

Top module: `adc_seq`

## Requirements
- R1: After reset the control byte reads 0x00. Its fields are: bit 7 enable, bit 6 start/busy, bit 5 auto-trigger enable, bit 4 completion flag, bit 3 interrupt enable, bits 2:0 prescaler code. Enable, auto-trigger, interrupt enable and prescaler read back as written.
- R2: Prescaler codes 0 to 7 divide the system clock by 2, 2, 4, 8, 16, 32, 64 and 128. The prescaler phase restarts whenever a conversion begins from idle, so a conversion of K converter clocks occupies exactly K times the divisor in system cycles.
- R3: Writing 1 to bit 6 together with 1 in bit 7 starts one conversion. Bit 6 reads 1 from the cycle after the write, for (W+13)·div cycles, where W is the warm-up count (or 0). A start written with bit 7 = 0 starts nothing.
- R4: The first conversion started after enable, including one started by the same write that sets enable, is preceded by `su_len` converter clocks of warm-up; `su_len` is sampled at the start. Later conversions have no warm-up.
- R5: Writing 0 to bit 6 has no effect. A start written while busy is ignored and does not lengthen the running conversion.
- R6: Writing bit 7 = 0 aborts a running conversion. Bit 6 reads 0 on the next cycle, and no result load or flag follows.
- R7: With auto-trigger enabled and `free_run` high, a single software start launches back-to-back conversions. `res_load` pulses every 13·div cycles. Clearing auto-trigger lets the current conversion finish and then stops.
- R8: With auto-trigger enabled and `free_run` low, a rising edge on `trig_in` starts a conversion. Bit 6 reads 1 after the third clock edge that samples `trig_in` high. Edges arriving while busy, or while auto-trigger is disabled, start nothing.
- R9: On completion, `res_load` pulses for one cycle and bit 4 is 1 from the next cycle. Bit 4 is cleared by writing 1 to it or by an `irq_ack` pulse. Writing 0 to it leaves it unchanged. A completion in the same cycle as a write-1 clear leaves the flag set.
- R10: `irq` is high exactly when bit 4, bit 3 and `glb_ie` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Data written to the control byte |
| rd_data | output | 8 | Control byte read value, bit 6 showing busy |
| su_len | input | 6 | Warm-up length in converter clocks |
| trig_in | input | 1 | Asynchronous external trigger |
| free_run | input | 1 | Trigger source select: 1 = continuous conversions |
| glb_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt serviced pulse, clears the flag |
| irq | output | 1 | Conversion-complete interrupt request |
| res_load | output | 1 | One-cycle strobe loading the result register |

## Verification
The bench uses the default parameters: a 13-clock conversion, a 6-bit warm-up length and a 3-bit prescaler code. With these defaults every divisor from 2 to 128 can be checked for exact busy length. Random runs draw warm-up lengths of 0 to 15, which keeps the slowest case under four thousand cycles. The runs still cover both first-after-enable and repeated conversions. Directed cases place a flag clear on the completion cycle, a start write in the middle of a conversion, and a trigger edge inside a conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WARM = 2'd1,
    ST_CONV = 2'd2
  } eng_state_t;
endpackage

// File: rtl/adc_seq_presc.sv
module adc_seq_presc #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] psel,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    if (psel == '0) lim = DIV_W'(1);
    else            lim = DIV_W'((DIV_W+1)'(1) << psel) - DIV_W'(1);
  end

  assign tick = run && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= trig_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q && !s3_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R8
endmodule

// File: rtl/adc_seq_eng.sv
module adc_seq_eng
  import adc_seq_pkg::*;
#(
  parameter int CONV_CLKS = 13,
  parameter int SU_W      = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            start,
  input  logic            repeat_ok,
  input  logic [SU_W-1:0] su_len,
  input  logic            tick,
  output logic            busy,
  output logic            done
);
  localparam int CONV_W = $clog2(CONV_CLKS + 1);
  localparam int CNT_W  = (SU_W > CONV_W) ? SU_W : CONV_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CLKS - 1);

  eng_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             first_q, first_d;

  assign busy = (state_q != ST_IDLE);
  assign done = en && (state_q == ST_CONV) && tick && (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    first_d = first_q;
    if (!en) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      first_d = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          first_d = 1'b0;
          if (first_q && su_len != '0) begin
            state_d = ST_WARM;
            cnt_d   = CNT_W'(su_len);
          end else begin
            state_d = ST_CONV;
            cnt_d   = '0;
          end
        end
        ST_WARM: if (tick) begin
          if (cnt_q == CNT_W'(1)) begin
            state_d = ST_CONV;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        ST_CONV: if (tick) begin
          if (cnt_q == LAST) begin
            state_d = repeat_ok ? ST_CONV : ST_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
    end
  end

  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    en && start && !busy |=> busy); // R3
  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy); // R6
endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int CONV_CLKS = 13,
  parameter int SU_W      = 6,
  parameter int PS_W      = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  output logic [7:0]      rd_data,
  input  logic [SU_W-1:0] su_len,
  input  logic            trig_in,
  input  logic            free_run,
  input  logic            glb_ie,
  input  logic            irq_ack,
  output logic            irq,
  output logic            res_load
);
  localparam int B_EN  = 7;
  localparam int B_GO  = 6;
  localparam int B_ATE = 5;
  localparam int B_FLG = 4;
  localparam int B_IE  = 3;

  logic            rq1, rs_n;
  logic            en_q, en_d, ate_q, ate_d, flg_q, flg_d, ie_q, ie_d;
  logic [PS_W-1:0] ps_q, ps_d;
  logic            busy, done, tick, rise, start;

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq1  <= 1'b0;
      rs_n <= 1'b0;
    end else begin
      rq1  <= 1'b1;
      rs_n <= rq1;
    end
  end

  always_comb begin
    en_d  = en_q;
    ate_d = ate_q;
    ie_d  = ie_q;
    ps_d  = ps_q;
    flg_d = flg_q;
    if (wr_en) begin
      en_d  = wr_data[B_EN];
      ate_d = wr_data[B_ATE];
      ie_d  = wr_data[B_IE];
      ps_d  = wr_data[PS_W-1:0];
    end
    if (done)                                flg_d = 1'b1;
    else if ((wr_en && wr_data[B_FLG]) || irq_ack) flg_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      en_q  <= 1'b0;
      ate_q <= 1'b0;
      flg_q <= 1'b0;
      ie_q  <= 1'b0;
      ps_q  <= '0;
    end else begin
      en_q  <= en_d;
      ate_q <= ate_d;
      flg_q <= flg_d;
      ie_q  <= ie_d;
      ps_q  <= ps_d;
    end
  end

  assign start = (wr_en && wr_data[B_EN] && wr_data[B_GO]) ||
                 (rise && en_q && ate_q && !free_run);

  adc_seq_trig u_trig (
    .clk     (clk),
    .rst_n   (rs_n),
    .trig_in (trig_in),
    .rise    (rise)
  );

  adc_seq_presc #(.PS_W(PS_W)) u_presc (
    .clk   (clk),
    .rst_n (rs_n),
    .run   (busy),
    .psel  (ps_q),
    .tick  (tick)
  );

  adc_seq_eng #(.CONV_CLKS(CONV_CLKS), .SU_W(SU_W)) u_eng (
    .clk       (clk),
    .rst_n     (rs_n),
    .en        (en_d),
    .start     (start),
    .repeat_ok (ate_q && free_run),
    .su_len    (su_len),
    .tick      (tick),
    .busy      (busy),
    .done      (done)
  );

  generate
    if (PS_W < 5) begin : g_rd_pad
      assign rd_data = {en_q, busy, ate_q, flg_q, ie_q, {(3-PS_W){1'b0}}, ps_q};
    end else begin : g_rd_full
      assign rd_data = {en_q, busy, ate_q, flg_q, ie_q, ps_q[2:0]};
    end
  endgenerate

  assign irq      = flg_q && ie_q && glb_ie;
  assign res_load = done;

  AST_FLAG_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rs_n)
    res_load |=> rd_data[B_FLG]); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rs_n)
    irq_ack && !res_load |=> !rd_data[B_FLG]); // R9
  AST_WR0_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rs_n)
    wr_en && !wr_data[B_FLG] && !irq_ack && rd_data[B_FLG] |=> rd_data[B_FLG]); // R9
  AST_LOAD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rs_n)
    res_load |-> rd_data[B_EN] && rd_data[B_GO]); // R6
endmodule

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [5:0] su_len;
  logic       trig_in, free_run, glb_ie, irq_ack;
  logic       irq, res_load;

  int checks = 0;
  int errors = 0;
  bit fresh = 1'b1;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  adc_seq u_adc_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .su_len(su_len), .trig_in(trig_in),
    .free_run(free_run), .glb_ie(glb_ie), .irq_ack(irq_ack),
    .irq(irq), .res_load(res_load)
  );

  function automatic int f_div(input int code);
    return (code == 0) ? 2 : (1 << code);
  endfunction

  function automatic int f_cycles(input int code, input int warm, input bit first);
    return ((first ? warm : 0) + 13) * f_div(code);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    if (!d[7]) fresh = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // counts busy samples; optional mid-run start write, flag clear on the load
  // cycle, and a trigger re-edge inside the conversion
  task automatic measure(output int n, output int loads, input bit mid_start,
                         input bit clr_at_load, input bit tgl, input logic [7:0] keep);
    n = 0;
    loads = 0;
    while (rd_data[6] && n < 20000) begin
      n++;
      if (res_load) begin
        loads++;
        if (clr_at_load) begin wr_en = 1'b1; wr_data = keep | 8'h10; end
      end else if (mid_start && n == 5) begin
        wr_en = 1'b1; wr_data = keep | 8'h40;
      end
      if (tgl && n == 3) trig_in = 1'b0;
      if (tgl && n == 8) trig_in = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, loads, seed, exp, code, warm;
    bit first, ms, cl;
    seed = $urandom(32'd2024);
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; su_len = '0;
    trig_in = 1'b0; free_run = 1'b0; glb_ie = 1'b0; irq_ack = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset value and field readback
    chk(rd_data == 8'h00, "R1 reset", rd_data, 0);
    wr(8'h2B);
    chk(rd_data == 8'h2B, "R1 readback", rd_data, 8'h2B);
    wr(8'h3C);
    chk(rd_data == 8'h2C, "R1 flag write1 when clear", rd_data, 8'h2C);

    // R3 start with enable low does nothing
    wr(8'h40);
    idle(5);
    chk(rd_data[6] == 1'b0, "R3 start without enable", rd_data[6], 0);

    // R2 every prescaler code, no warm-up
    su_len = 6'd0;
    for (int c = 0; c < 8; c++) begin
      wr(8'hC0 | 8'(c));
      fresh = 1'b0;
      measure(n, loads, 1'b0, 1'b0, 1'b0, 8'h80 | 8'(c));
      chk(n == f_cycles(c, 0, 1'b0), "R2 divisor", n, f_cycles(c, 0, 1'b0));
    end

    // R3 R4 R5 R9 random runs with fixed seed
    for (int i = 0; i < 14; i++) begin
      code  = int'($urandom % 8);
      warm  = int'($urandom % 16);
      first = 1'($urandom % 2);
      ms    = 1'($urandom % 2);
      cl    = (i % 4 == 3);
      su_len = 6'(warm);
      if (first) wr(8'h10);
      else       wr(8'h90 | 8'(code));
      exp = f_cycles(code, warm, fresh);
      wr(8'hC0 | 8'(code));
      fresh = 1'b0;
      measure(n, loads, ms, cl, 1'b0, 8'h80 | 8'(code));
      chk(n == exp, "R3 R4 busy length", n, exp);
      chk(loads == 1, "R9 one result load", loads, 1);
      chk(rd_data[4] == 1'b1, cl ? "R9 set wins over clear" : "R9 flag set", rd_data[4], 1);
    end

    // R5 writing 0 to start bit while idle
    su_len = 6'd0;
    wr(8'h81);
    idle(4);
    chk(rd_data[6] == 1'b0, "R5 write0 start no effect", rd_data[6], 0);

    // R9 write 0 keeps flag, irq_ack clears; R10 gating
    wr(8'hC9);
    measure(n, loads, 1'b0, 1'b0, 1'b0, 8'h89);
    glb_ie = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R10 irq all set", irq, 1);
    glb_ie = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R10 irq global off", irq, 0);
    glb_ie = 1'b1;
    wr(8'h81);
    chk(rd_data[4] == 1'b1, "R9 write0 keeps flag", rd_data[4], 1);
    chk(irq == 1'b0, "R10 irq local off", irq, 0);
    wr(8'h89);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk(rd_data[4] == 1'b0, "R9 ack clears", rd_data[4], 0);
    chk(irq == 1'b0, "R10 irq after ack", irq, 0);
    wr(8'hC1);
    measure(n, loads, 1'b0, 1'b0, 1'b0, 8'h81);
    wr(8'h91);
    chk(rd_data[4] == 1'b0, "R9 write1 clears", rd_data[4], 0);

    // R6 abort
    wr(8'hC3);
    idle(20);
    wr(8'h03);
    chk(rd_data[6] == 1'b0, "R6 abort busy", rd_data[6], 0);
    loads = 0;
    for (int k = 0; k < 150; k++) begin
      if (res_load) loads++;
      @(negedge clk);
    end
    chk(loads == 0 && rd_data[4] == 1'b0, "R6 no load after abort", loads, 0);

    // R8 trigger timing and edge while busy
    wr(8'hA1);
    @(negedge clk);
    trig_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(rd_data[6] == 1'b0, "R8 trigger latency early", rd_data[6], 0);
    @(negedge clk);
    chk(rd_data[6] == 1'b1, "R8 trigger latency", rd_data[6], 1);
    measure(n, loads, 1'b0, 1'b0, 1'b1, 8'hA1);
    chk(n == 26, "R8 busy edge ignored length", n, 26);
    idle(10);
    chk(rd_data[6] == 1'b0, "R8 edge while busy ignored", rd_data[6], 0);
    wr(8'h81);
    trig_in = 1'b0;
    idle(3);
    trig_in = 1'b1;
    idle(6);
    chk(rd_data[6] == 1'b0, "R8 trigger disabled", rd_data[6], 0);
    trig_in = 1'b0;

    // R7 free running
    free_run = 1'b1;
    wr(8'hE1);
    n = 0;
    while (!res_load && n < 1000) begin n++; @(negedge clk); end
    @(negedge clk);
    n = 1;
    while (!res_load && n < 1000) begin n++; @(negedge clk); end
    chk(n == 26, "R7 free-run period", n, 26);
    chk(rd_data[6] == 1'b1, "R7 stays busy", rd_data[6], 1);
    idle(3);
    wr(8'h81);
    measure(n, loads, 1'b0, 1'b0, 1'b0, 8'h81);
    chk(loads == 1, "R7 finishes current", loads, 1);
    idle(60);
    chk(rd_data[6] == 1'b0, "R7 stopped", rd_data[6], 0);
    free_run = 1'b0;

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule